// File: doc/BRIEF.md
# Timer Compare Waveform Generator

This block holds a 16-bit up-counter and three compare channels (A, B and C). Together they produce pulse or level waveforms on three output bits. A 4-bit mode register picks how the counter runs. In plain counting, the counter covers the full 16-bit range and wraps to zero. In fast PWM, the counter restarts at zero on the clock after it reaches a TOP value. TOP is either a fixed 8, 9 or 10-bit limit, a separate TOP register, or the active compare value of channel A.

Each channel has a compare value and a 2-bit action code. What the code does depends on the counting mode. In plain counting, a match can toggle, clear or set the output. In fast PWM, a match clears the output and TOP sets it, or the inverse. A per-channel enable tells the surrounding pin logic whether the waveform owns the pin. The mode, the codes, the compare values and the TOP register are each written through a data input paired with a one-cycle write strobe.

Top module: `tmr_wave_top`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, the counter, all outputs, all compare values, the codes and the mode are zero.
- R2: Mode 0, and every mode value other than 5, 6, 7, 14 and 15, counts up by one per clock and wraps from 0xFFFF to 0.
- R3: In plain counting, code 01 toggles, code 10 drives low and code 11 drives high. The output changes on the clock edge at which the counter equals the active compare value, so it is first seen when the counter reads that value plus one.
- R4: Code 00 disconnects a channel. Its `pin_en` bit is 0 and its output bit holds its value whatever the counter does.
- R5: Modes 5, 6 and 7 are fast PWM with TOP of 0x00FF, 0x01FF and 0x03FF. The counter goes to 0 on the clock after it reads TOP.
- R6: Mode 14 is fast PWM with TOP taken from the TOP register. Mode 15 is fast PWM with TOP equal to the active compare value of channel A.
- R7: In fast PWM, code 10 drives the output high at TOP and low on a match. Code 11 drives it low at TOP and high on a match.
- R8: In fast PWM, code 01 toggles channel A on a match only in modes 14 and 15. In every other case, code 01 in fast PWM leaves the channel disconnected (`pin_en` bit 0).
- R9: When one clock holds both a TOP action and a match on a channel, only the TOP action is applied. A compare value equal to TOP with code 10 or 11 therefore yields only the TOP level.
- R10: In plain counting, a compare write takes effect on the next clock. In fast PWM, a compare write is held in a shadow register and copied to the active value only on the clock at which the counter reads TOP.
- R11: Each `pin_en` bit is 1 exactly when the channel's code, under the current mode, selects an action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wgm_wr | input | 1 | Write strobe for the counting mode |
| wgm_in | input | 4 | Counting mode value |
| top_wr | input | 1 | Write strobe for the TOP register |
| top_in | input | 16 | TOP register value |
| cmp_wr | input | 3 | Per-channel compare write strobes (bit 0 = A) |
| cmp_in | input | 16 | Compare value |
| com_wr | input | 3 | Per-channel action code write strobes (bit 0 = A) |
| com_in | input | 2 | Action code |
| cnt_o | output | 16 | Current counter value |
| wave_out | output | 3 | Waveform outputs (bit 0 = A) |
| pin_en | output | 3 | Waveform owns the pin, per channel |

## Verification
A wrong TOP selection shows on `cnt_o` within one period: the counter either fails to return to zero on the clock after the expected TOP, or returns early. A wrong active compare value moves the edge of `wave_out` to another counter value. With double buffering, that shift appears only after the next TOP, so the checks sample both the current period and the one that follows a write. A wrong action decode shows at once on `pin_en` and, at the next match or TOP, on `wave_out`. The bench samples each edge on the cycle after the counter reads the match or TOP value.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

    localparam logic [3:0] WGM_PWM8     = 4'd5;
    localparam logic [3:0] WGM_PWM9     = 4'd6;
    localparam logic [3:0] WGM_PWM10    = 4'd7;
    localparam logic [3:0] WGM_PWM_TREG = 4'd14;
    localparam logic [3:0] WGM_PWM_TCMP = 4'd15;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TGL,
        ACT_CLR,
        ACT_SET,
        ACT_NONINV,
        ACT_INV
    } wave_act_e;

    // Map the 2-bit code to the action it selects under the current mode.
    function automatic wave_act_e decode_act(input logic [1:0] code,
                                             input logic       pwm,
                                             input logic       tgl_ok);
        wave_act_e a;
        case (code)
            2'b01:   a = (!pwm || tgl_ok) ? ACT_TGL : ACT_NONE;
            2'b10:   a = pwm ? ACT_NONINV : ACT_CLR;
            2'b11:   a = pwm ? ACT_INV : ACT_SET;
            default: a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tmr_wave_counter.sv
module tmr_wave_counter
    import tmr_wave_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wgm_wr,
    input  logic [3:0]       wgm_in,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_in,
    input  logic [CNT_W-1:0] cmp_a_act,
    output logic [CNT_W-1:0] cnt_o,
    output logic [3:0]       wgm_o,
    output logic             is_pwm,
    output logic             at_top
);

    localparam logic [CNT_W-1:0] TOP8  = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] TOP9  = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] TOP10 = CNT_W'((1 << 10) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [3:0]       wgm;
        logic [CNT_W-1:0] treg;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] top_val;
    logic             pwm_c;
    logic             at_top_c;

    always_comb begin
        st_d    = st_q;
        top_val = '1;
        pwm_c   = 1'b0;
        case (st_q.wgm)
            WGM_PWM8:     begin top_val = TOP8;      pwm_c = 1'b1; end
            WGM_PWM9:     begin top_val = TOP9;      pwm_c = 1'b1; end
            WGM_PWM10:    begin top_val = TOP10;     pwm_c = 1'b1; end
            WGM_PWM_TREG: begin top_val = st_q.treg; pwm_c = 1'b1; end
            WGM_PWM_TCMP: begin top_val = cmp_a_act; pwm_c = 1'b1; end
            default:      begin top_val = '1;        pwm_c = 1'b0; end
        endcase
        at_top_c = (st_q.cnt == top_val);
        st_d.cnt = at_top_c ? '0 : st_q.cnt + 1'b1;
        if (wgm_wr) st_d.wgm  = wgm_in;
        if (top_wr) st_d.treg = top_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wgm_o  = st_q.wgm;
    assign is_pwm = pwm_c;
    assign at_top = at_top_c;

endmodule

// File: rtl/tmr_wave_cmpbuf.sv
module tmr_wave_cmpbuf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] din,
    input  logic             is_pwm,
    input  logic             at_top,
    output logic [CNT_W-1:0] act_o
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] act;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.shadow = din;
        if (!is_pwm)     st_d.act = st_d.shadow;
        else if (at_top) st_d.act = st_q.shadow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
    import tmr_wave_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter bit IS_A  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             com_wr,
    input  logic [1:0]       com_in,
    input  logic [3:0]       wgm,
    input  logic             is_pwm,
    input  logic             at_top,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    output logic             wave_o,
    output logic             pin_en_o,
    output logic [1:0]       com_o
);

    typedef struct packed {
        logic [1:0] com;
        logic       wave;
    } ch_st_t;

    ch_st_t    st_d, st_q;
    wave_act_e act;
    logic      tgl_ok;
    logic      hit;

    always_comb begin
        st_d   = st_q;
        tgl_ok = IS_A && ((wgm == WGM_PWM_TREG) || (wgm == WGM_PWM_TCMP));
        act    = decode_act(st_q.com, is_pwm, tgl_ok);
        hit    = (cnt == cmp_act);
        case (act)
            ACT_TGL: if (hit) st_d.wave = ~st_q.wave;
            ACT_CLR: if (hit) st_d.wave = 1'b0;
            ACT_SET: if (hit) st_d.wave = 1'b1;
            ACT_NONINV: begin
                if (at_top)   st_d.wave = 1'b1;
                else if (hit) st_d.wave = 1'b0;
            end
            ACT_INV: begin
                if (at_top)   st_d.wave = 1'b0;
                else if (hit) st_d.wave = 1'b1;
            end
            default: st_d.wave = st_q.wave;
        endcase
        if (com_wr) st_d.com = com_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave_o   = st_q.wave;
    assign pin_en_o = (act != ACT_NONE);
    assign com_o    = st_q.com;

endmodule

// File: rtl/tmr_wave_top.sv
module tmr_wave_top #(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wgm_wr,
    input  logic [3:0]       wgm_in,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_in,
    input  logic [NCH-1:0]   cmp_wr,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [NCH-1:0]   com_wr,
    input  logic [1:0]       com_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic [NCH-1:0]   wave_out,
    output logic [NCH-1:0]   pin_en
);

    logic [3:0]                 wgm_q;
    logic                       is_pwm;
    logic                       at_top;
    logic [NCH-1:0][CNT_W-1:0]  cmp_act;
    logic [NCH-1:0][1:0]        com_q;

    tmr_wave_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wgm_wr    (wgm_wr),
        .wgm_in    (wgm_in),
        .top_wr    (top_wr),
        .top_in    (top_in),
        .cmp_a_act (cmp_act[0]),
        .cnt_o     (cnt_o),
        .wgm_o     (wgm_q),
        .is_pwm    (is_pwm),
        .at_top    (at_top)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_wave_cmpbuf #(.CNT_W(CNT_W)) u_buf (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (cmp_wr[g]),
            .din    (cmp_in),
            .is_pwm (is_pwm),
            .at_top (at_top),
            .act_o  (cmp_act[g])
        );

        tmr_wave_chan #(.CNT_W(CNT_W), .IS_A(g == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .com_wr   (com_wr[g]),
            .com_in   (com_in),
            .wgm      (wgm_q),
            .is_pwm   (is_pwm),
            .at_top   (at_top),
            .cnt      (cnt_o),
            .cmp_act  (cmp_act[g]),
            .wave_o   (wave_out[g]),
            .pin_en_o (pin_en[g]),
            .com_o    (com_q[g])
        );
    end

endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CNT_W-1:0]          cnt_o,
    input logic [NCH-1:0]            wave_out,
    input logic [NCH-1:0]            pin_en,
    input logic                      is_pwm,
    input logic                      at_top,
    input logic [NCH-1:0][1:0]       com_q,
    input logic [NCH-1:0][CNT_W-1:0] cmp_act
);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !at_top |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

    // R5
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |=> cnt_o == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_c
        // R4
        hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_en[g] |=> wave_out[g] == $past(wave_out[g]));

        // R7
        noninv_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pwm && com_q[g] == 2'b10 && at_top) |=> wave_out[g]);

        // R7
        inv_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pwm && com_q[g] == 2'b11 && at_top) |=> !wave_out[g]);

        // R10
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pwm && !at_top) |=> $stable(cmp_act[g]));

        if (g > 0) begin : g_bc
            // R8
            no_tgl_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (is_pwm && com_q[g] == 2'b01) |-> !pin_en[g]);
        end
    end

endmodule

bind tmr_wave_top tmr_wave_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_o    (cnt_o),
    .wave_out (wave_out),
    .pin_en   (pin_en),
    .is_pwm   (is_pwm),
    .at_top   (at_top),
    .com_q    (com_q),
    .cmp_act  (cmp_act)
);

// File: tb/sim_tmr_wave_top.sv
module sim_tmr_wave_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wgm_wr = 1'b0;
    logic [3:0]  wgm_in = '0;
    logic        top_wr = 1'b0;
    logic [15:0] top_in = '0;
    logic [2:0]  cmp_wr = '0;
    logic [15:0] cmp_in = '0;
    logic [2:0]  com_wr = '0;
    logic [1:0]  com_in = '0;
    logic [15:0] cnt_o;
    logic [2:0]  wave_out;
    logic [2:0]  pin_en;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_wave_top #(.CNT_W(16), .NCH(NCH)) u0 (
        .clk (clk), .rst_n (rst_n),
        .wgm_wr (wgm_wr), .wgm_in (wgm_in),
        .top_wr (top_wr), .top_in (top_in),
        .cmp_wr (cmp_wr), .cmp_in (cmp_in),
        .com_wr (com_wr), .com_in (com_in),
        .cnt_o (cnt_o), .wave_out (wave_out), .pin_en (pin_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h (cnt=%0h)", req, act, exp, cnt_o);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_wgm(input logic [3:0] v);
        wgm_in = v; wgm_wr = 1'b1;
        @(negedge clk);
        wgm_wr = 1'b0;
    endtask

    task automatic wr_top(input logic [15:0] v);
        top_in = v; top_wr = 1'b1;
        @(negedge clk);
        top_wr = 1'b0;
    endtask

    task automatic wr_cmp(input int ch, input logic [15:0] v);
        cmp_in = v; cmp_wr = 3'b001 << ch;
        @(negedge clk);
        cmp_wr = '0;
    endtask

    task automatic wr_com(input int ch, input logic [1:0] v);
        com_in = v; com_wr = 3'b001 << ch;
        @(negedge clk);
        com_wr = '0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        int n = 0;
        while (cnt_o !== v && n < 70000) begin
            @(negedge clk);
            n++;
        end
        if (cnt_o !== v) chk("wait", 32'(cnt_o), 32'(v));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cnt", 32'(cnt_o), 0);
        chk("R1 wave", 32'(wave_out), 0);
        chk("R1 pin_en", 32'(pin_en), 0);
    endtask

    task automatic t_plain();
        do_reset();
        wr_cmp(0, 16'd20); wr_cmp(1, 16'd30); wr_cmp(2, 16'd40);
        wr_com(0, 2'b01); wr_com(1, 2'b11); wr_com(2, 2'b10);
        chk("R11 pin_en plain", 32'(pin_en), 32'b111);
        wait_cnt(16'd20); chk("R3 toggle before", 32'(wave_out[0]), 0);
        @(negedge clk);   chk("R3 toggle after", 32'(wave_out[0]), 1);
        wait_cnt(16'd31); chk("R3 set", 32'(wave_out[1]), 1);
        wr_cmp(1, 16'd60); wr_com(1, 2'b10);
        wait_cnt(16'd60); chk("R10 plain immediate before", 32'(wave_out[1]), 1);
        @(negedge clk);   chk("R3 R10 clear", 32'(wave_out[1]), 0);
        wr_com(0, 2'b00);
        chk("R4 pin_en off", 32'(pin_en[0]), 0);
        wr_cmp(0, 16'd100);
        wait_cnt(16'd102); chk("R4 hold", 32'(wave_out[0]), 1);
        wr_wgm(4'd9);
        wait_cnt(16'hFFFF);
        @(negedge clk); chk("R2 wrap", 32'(cnt_o), 0);
        @(negedge clk); chk("R2 step", 32'(cnt_o), 1);
        chk("R4 hold after wrap", 32'(wave_out[0]), 1);
    endtask

    task automatic t_pwm_fixed();
        do_reset();
        chk("R1 wave after reset", 32'(wave_out), 0);
        wr_cmp(0, 16'h40); wr_cmp(1, 16'h80);
        wr_com(0, 2'b10);  wr_com(1, 2'b11);
        wr_wgm(4'd5);
        wait_cnt(16'hFF);
        @(negedge clk); chk("R5 top 8", 32'(cnt_o), 0);
        chk("R7 noninv set at top", 32'(wave_out[0]), 1);
        wait_cnt(16'h41); chk("R7 noninv clear", 32'(wave_out[0]), 0);
        wait_cnt(16'h81); chk("R7 inv set", 32'(wave_out[1]), 1);
        wait_cnt(16'hFF);
        @(negedge clk); chk("R7 inv clear at top", 32'(wave_out[1]), 0);
        wr_wgm(4'd6);
        wait_cnt(16'h1FF);
        @(negedge clk); chk("R5 top 9", 32'(cnt_o), 0);
        wr_wgm(4'd7);
        wait_cnt(16'h3FF);
        @(negedge clk); chk("R5 top 10", 32'(cnt_o), 0);
    endtask

    task automatic t_pwm_reg();
        do_reset();
        wr_top(16'h30); wr_cmp(0, 16'h10); wr_com(0, 2'b10);
        wr_wgm(4'd14);
        wait_cnt(16'h30);
        @(negedge clk); chk("R6 top reg", 32'(cnt_o), 0);
        wr_cmp(0, 16'h20);
        wait_cnt(16'h11); chk("R10 old value kept", 32'(wave_out[0]), 0);
        wait_cnt(16'h30);
        @(negedge clk); chk("R7 set at top", 32'(wave_out[0]), 1);
        wait_cnt(16'h11); chk("R10 new value after top", 32'(wave_out[0]), 1);
        wait_cnt(16'h21); chk("R10 new match", 32'(wave_out[0]), 0);
    endtask

    task automatic t_pwm_tgl();
        do_reset();
        wr_cmp(0, 16'h20); wr_cmp(1, 16'h10);
        wr_com(0, 2'b01);  wr_com(1, 2'b01);
        wr_wgm(4'd15);
        chk("R8 R11 only A enabled", 32'(pin_en), 32'b001);
        wait_cnt(16'h20);
        @(negedge clk); chk("R6 top cmp A", 32'(cnt_o), 0);
        chk("R8 toggle 1", 32'(wave_out[0]), 1);
        wait_cnt(16'h20);
        @(negedge clk); chk("R8 toggle 2", 32'(wave_out[0]), 0);
        chk("R8 B untouched", 32'(wave_out[1]), 0);
        wr_wgm(4'd5);
        chk("R8 A off in fixed mode", 32'(pin_en), 0);
    endtask

    task automatic t_top_eq();
        do_reset();
        wr_cmp(0, 16'hFF); wr_com(0, 2'b10);
        wr_cmp(1, 16'hFF); wr_com(1, 2'b11);
        wr_cmp(2, 16'h10); wr_com(2, 2'b10);
        wr_wgm(4'd5);
        wait_cnt(16'hFF);
        @(negedge clk); chk("R9 A top only", 32'(wave_out[0]), 1);
        chk("R9 B top only", 32'(wave_out[1]), 0);
        chk("R7 C set", 32'(wave_out[2]), 1);
        wait_cnt(16'h11); chk("R7 C clear", 32'(wave_out[2]), 0);
        wait_cnt(16'hFF);
        @(negedge clk); chk("R9 A stays high", 32'(wave_out[0]), 1);
        wait_cnt(16'h80); chk("R9 A mid period", 32'(wave_out[0]), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_plain();
        t_pwm_fixed();
        t_pwm_reg();
        t_pwm_tgl();
        t_top_eq();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule